// File: doc/BRIEF.md
# Machine-Mode Trap Sequencer

This block decides where instruction fetch goes when a trap is taken or when a trap handler returns. It also keeps the machine-mode trap state: the saved program counter, the cause word, the trap-vector base with its mode bit, and the two interrupt-enable bits of the status word. The core presents a trap request that carries an interrupt-or-exception flag, a cause code, a vector of simultaneous exception requests and the faulting PC. The block picks the winning exception and updates the trap state. It then emits a redirect address: the vector base for exceptions, and base or base plus four times the interrupt number for interrupts. A return request sends fetch back to the saved PC and restores the enable bit.

Redirect addresses leave the block as a stream. `redir_valid_o` stays high, with `redir_addr_o` stable, until the consumer raises `redir_ready_i`. While a redirect is waiting, `evt_ready_o` is low. A trap or return offered in that state is not taken, and the requester must hold it. Straight after reset the block offers one redirect to `boot_addr_i`. A simple register port lets software read the trap state and write the status, vector base and saved PC. Writes through this port take effect at once and are never back-pressured.

Top module: `trap_unit`

## Requirements
- R1: After reset, the block offers a redirect to `boot_addr_i` (`redir_valid_o`=1). The status word, saved PC and cause all read 0, and the vector-base register reads `MTVEC_INIT` with bits 7:1 forced to 0.
- R2: When a trap is taken, the saved PC becomes `trap_pc_i`. Status bit 7 (previous enable) takes the old value of bit 3 (enable), and bit 3 is cleared.
- R3: A taken exception (`trap_irq_i`=0) redirects to the vector base (register bits 31:8, with the low byte zero), whatever the mode bit holds.
- R4: A taken interrupt redirects to base + 4 × `trap_code_i[IRQ_ID_W-1:0]` when the vector-base bit 0 is 1 (vectored), and to the base when bit 0 is 0 (direct).
- R5: After a trap, cause bit 31 equals `trap_irq_i`, and the low 11 bits hold the cause code. For an interrupt this code is `trap_code_i`.
- R6: For an exception, the lowest set index of `exc_vec_i` wins. Index 0 to 8 give codes 1, 49, 48, 2, 8, 11, 3, 7, 5 in that order.
- R7: An exception with an all-zero `exc_vec_i` records `trap_code_i` as its cause code.
- R8: A taken return (`mret_i`) redirects to the saved PC. Status bit 3 takes bit 7, and bit 7 is set to 1.
- R9: When a trap and a return are offered in the same cycle, only the trap takes effect.
- R10: A vector-base write stores bits 31:8 and bit 0 and reads bits 7:1 as 0. A status write keeps only bits 3 and 7. A write to the cause register has no effect.
- R11: While `redir_valid_o`=1 and `redir_ready_i`=0, the address holds and `evt_ready_o`=0. Traps and returns offered then change no state. The redirect drops one cycle after it is accepted if no new event arrives.
- R12: When a trap is taken in the same cycle as a software write to the saved PC or the status word, the trap's update wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| boot_addr_i | input | XLEN | First fetch address after reset |
| trap_valid_i | input | 1 | Trap request |
| trap_irq_i | input | 1 | 1 = interrupt, 0 = exception |
| trap_code_i | input | 11 | Interrupt number, or fallback exception code |
| exc_vec_i | input | NUM_EXC | Simultaneous exception requests, index 0 highest priority |
| trap_pc_i | input | XLEN | PC to save on trap entry |
| mret_i | input | 1 | Return-from-trap request |
| evt_ready_o | output | 1 | Trap or return can be taken this cycle |
| redir_valid_o | output | 1 | Redirect address offered |
| redir_ready_i | input | 1 | Consumer accepts the redirect |
| redir_addr_o | output | XLEN | Redirect target |
| csr_we_i | input | 1 | Register write strobe |
| csr_sel_i | input | 2 | 0 status, 1 vector base, 2 saved PC, 3 cause |
| csr_wdata_i | input | XLEN | Register write data |
| csr_rdata_o | output | XLEN | Combinational read of the selected register |

## Verification
A corrupted saved PC or enable bit stays hidden until the next return. At that point it shows as a wrong redirect address, or as a wrong status read, in the cycle after the return is taken. A wrong priority pick or a wrong vector base shows on the cause read and on the redirect address one cycle after the trap. The stream rules are checked by holding the consumer off for several cycles and offering events meanwhile. This exposes a lost or altered address, or a state change that should have waited.

// File: rtl/trap_pkg.sv
package trap_pkg;

  localparam int CAUSE_W = 11;
  localparam int STAT_EN_BIT = 3;
  localparam int STAT_PREV_BIT = 7;
  localparam int VEC_ALIGN_BITS = 8;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_VBASE  = 2'd1,
    SEL_EPC    = 2'd2,
    SEL_CAUSE  = 2'd3
  } csr_sel_e;

  // exception code by priority rank, rank 0 highest
  function automatic logic [CAUSE_W-1:0] rank_code(input int rank);
    logic [CAUSE_W-1:0] c;
    case (rank)
      0:       c = CAUSE_W'(1);
      1:       c = CAUSE_W'(49);
      2:       c = CAUSE_W'(48);
      3:       c = CAUSE_W'(2);
      4:       c = CAUSE_W'(8);
      5:       c = CAUSE_W'(11);
      6:       c = CAUSE_W'(3);
      7:       c = CAUSE_W'(7);
      default: c = CAUSE_W'(5);
    endcase
    return c;
  endfunction

endpackage

// File: rtl/trap_exc_arbiter.sv
module trap_exc_arbiter #(
  parameter int NUM_EXC = 9,
  parameter int CW = 11
) (
  input  logic [NUM_EXC-1:0] req_i,
  output logic               any_o,
  output logic [CW-1:0]      code_o
);
  always_comb begin
    any_o  = |req_i;
    code_o = '0;
    for (int i = NUM_EXC - 1; i >= 0; i--) begin
      if (req_i[i]) code_o = CW'(trap_pkg::rank_code(i));
    end
  end
endmodule

// File: rtl/trap_target_gen.sv
module trap_target_gen #(
  parameter int XLEN = 32,
  parameter int IRQ_ID_W = 5
) (
  input  logic [XLEN-1:0]     base_i,
  input  logic                vectored_i,
  input  logic                is_irq_i,
  input  logic [IRQ_ID_W-1:0] irq_id_i,
  output logic [XLEN-1:0]     target_o
);
  localparam int OFF_W = IRQ_ID_W + 2;
  logic [XLEN-1:0] offset;

  assign offset   = {{(XLEN-OFF_W){1'b0}}, irq_id_i, 2'b00};
  assign target_o = (is_irq_i && vectored_i) ? base_i + offset : base_i;
endmodule

// File: rtl/trap_csr_regs.sv
module trap_csr_regs #(
  parameter int XLEN = 32,
  parameter int CW = 11,
  parameter logic [XLEN-1:0] MTVEC_INIT = 32'h0000_2001
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   csr_we_i,
  input  trap_pkg::csr_sel_e     csr_sel_i,
  input  logic [XLEN-1:0]        csr_wdata_i,
  input  logic                   trap_take_i,
  input  logic                   trap_irq_i,
  input  logic [CW-1:0]          trap_code_i,
  input  logic [XLEN-1:0]        trap_pc_i,
  input  logic                   mret_take_i,
  output logic [XLEN-1:0]        epc_o,
  output logic [XLEN-1:0]        vbase_o,
  output logic                   vmode_o,
  output logic                   cause_irq_o,
  output logic [CW-1:0]          cause_code_o,
  output logic                   en_o,
  output logic                   prev_en_o
);
  localparam int AB = trap_pkg::VEC_ALIGN_BITS;
  localparam logic [XLEN-AB-1:0] VBASE_RST = MTVEC_INIT[XLEN-1:AB];
  localparam logic VMODE_RST = MTVEC_INIT[0];

  logic [XLEN-AB-1:0] vbase_hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      epc_o        <= '0;
      vbase_hi_q   <= VBASE_RST;
      vmode_o      <= VMODE_RST;
      cause_irq_o  <= 1'b0;
      cause_code_o <= '0;
      en_o         <= 1'b0;
      prev_en_o    <= 1'b0;
    end else begin
      if (csr_we_i) begin
        case (csr_sel_i)
          trap_pkg::SEL_STATUS: begin
            en_o      <= csr_wdata_i[trap_pkg::STAT_EN_BIT];
            prev_en_o <= csr_wdata_i[trap_pkg::STAT_PREV_BIT];
          end
          trap_pkg::SEL_VBASE: begin
            vbase_hi_q <= csr_wdata_i[XLEN-1:AB];
            vmode_o    <= csr_wdata_i[0];
          end
          trap_pkg::SEL_EPC: epc_o <= csr_wdata_i;
          default: ;
        endcase
      end
      // hardware events override software writes of the same cycle
      if (trap_take_i) begin
        epc_o        <= trap_pc_i;
        cause_irq_o  <= trap_irq_i;
        cause_code_o <= trap_code_i;
        prev_en_o    <= en_o;
        en_o         <= 1'b0;
      end else if (mret_take_i) begin
        en_o      <= prev_en_o;
        prev_en_o <= 1'b1;
      end
    end
  end

  assign vbase_o = {vbase_hi_q, {AB{1'b0}}};
endmodule

// File: rtl/trap_unit.sv
module trap_unit #(
  parameter int XLEN = 32,
  parameter int IRQ_ID_W = 5,
  parameter int NUM_EXC = 9,
  parameter logic [XLEN-1:0] MTVEC_INIT = 32'h0000_2001,
  localparam int CW = trap_pkg::CAUSE_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [XLEN-1:0]    boot_addr_i,
  input  logic               trap_valid_i,
  input  logic               trap_irq_i,
  input  logic [CW-1:0]      trap_code_i,
  input  logic [NUM_EXC-1:0] exc_vec_i,
  input  logic [XLEN-1:0]    trap_pc_i,
  input  logic               mret_i,
  output logic               evt_ready_o,
  output logic               redir_valid_o,
  input  logic               redir_ready_i,
  output logic [XLEN-1:0]    redir_addr_o,
  input  logic               csr_we_i,
  input  logic [1:0]         csr_sel_i,
  input  logic [XLEN-1:0]    csr_wdata_i,
  output logic [XLEN-1:0]    csr_rdata_o
);
  localparam int PAD_W = XLEN - 1 - CW;

  logic            trap_take, mret_take;
  logic            exc_any;
  logic [CW-1:0]   exc_code, cause_in;
  logic [XLEN-1:0] epc, vbase, target, next_addr;
  logic            vmode, cause_irq, en, prev_en;
  logic [CW-1:0]   cause_code;
  logic            redir_boot_q;
  logic [XLEN-1:0] redir_addr_q;
  trap_pkg::csr_sel_e sel;

  assign sel         = trap_pkg::csr_sel_e'(csr_sel_i);
  assign evt_ready_o = !redir_valid_o || redir_ready_i;
  assign trap_take   = trap_valid_i && evt_ready_o;
  assign mret_take   = mret_i && !trap_valid_i && evt_ready_o;

  trap_exc_arbiter #(.NUM_EXC(NUM_EXC), .CW(CW)) u_arb (
    .req_i  (exc_vec_i),
    .any_o  (exc_any),
    .code_o (exc_code)
  );

  assign cause_in = (trap_irq_i || !exc_any) ? trap_code_i : exc_code;

  trap_target_gen #(.XLEN(XLEN), .IRQ_ID_W(IRQ_ID_W)) u_tgt (
    .base_i     (vbase),
    .vectored_i (vmode),
    .is_irq_i   (trap_irq_i),
    .irq_id_i   (trap_code_i[IRQ_ID_W-1:0]),
    .target_o   (target)
  );

  trap_csr_regs #(.XLEN(XLEN), .CW(CW), .MTVEC_INIT(MTVEC_INIT)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .csr_we_i     (csr_we_i),
    .csr_sel_i    (sel),
    .csr_wdata_i  (csr_wdata_i),
    .trap_take_i  (trap_take),
    .trap_irq_i   (trap_irq_i),
    .trap_code_i  (cause_in),
    .trap_pc_i    (trap_pc_i),
    .mret_take_i  (mret_take),
    .epc_o        (epc),
    .vbase_o      (vbase),
    .vmode_o      (vmode),
    .cause_irq_o  (cause_irq),
    .cause_code_o (cause_code),
    .en_o         (en),
    .prev_en_o    (prev_en)
  );

  assign next_addr = trap_take ? target : epc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      redir_valid_o <= 1'b1;
      redir_boot_q  <= 1'b1;
      redir_addr_q  <= '0;
    end else if (trap_take || mret_take) begin
      redir_valid_o <= 1'b1;
      redir_boot_q  <= 1'b0;
      redir_addr_q  <= next_addr;
    end else if (redir_ready_i) begin
      redir_valid_o <= 1'b0;
      redir_boot_q  <= 1'b0;
    end
  end

  assign redir_addr_o = redir_boot_q ? boot_addr_i : redir_addr_q;

  always_comb begin
    csr_rdata_o = '0;
    case (sel)
      trap_pkg::SEL_STATUS: begin
        csr_rdata_o[trap_pkg::STAT_EN_BIT]   = en;
        csr_rdata_o[trap_pkg::STAT_PREV_BIT] = prev_en;
      end
      trap_pkg::SEL_VBASE: csr_rdata_o = {vbase[XLEN-1:1], vmode};
      trap_pkg::SEL_EPC:   csr_rdata_o = epc;
      default:             csr_rdata_o = {cause_irq, {PAD_W{1'b0}}, cause_code};
    endcase
  end
endmodule

// File: rtl/trap_unit_chk.sv
module trap_unit_chk #(
  parameter int XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            trap_take,
  input logic            mret_take,
  input logic            trap_irq_i,
  input logic [XLEN-1:0] trap_pc_i,
  input logic [XLEN-1:0] epc,
  input logic [XLEN-1:0] vbase,
  input logic            en,
  input logic            prev_en,
  input logic            cause_irq,
  input logic            redir_valid_o,
  input logic            redir_ready_i,
  input logic            redir_boot_q,
  input logic [XLEN-1:0] redir_addr_o
);
  AST_ENTRY_SAVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_take |=> (epc == $past(trap_pc_i)) && (prev_en == $past(en)) && !en); // R2

  AST_EXC_TO_BASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_take && !trap_irq_i) |=> redir_addr_o == $past(vbase)); // R3

  AST_CAUSE_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_take |=> cause_irq == $past(trap_irq_i)); // R5

  AST_RETURN_RESTORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mret_take |=> (redir_addr_o == $past(epc)) && (en == $past(prev_en)) && prev_en); // R8

  AST_REDIR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (redir_valid_o && !redir_ready_i && !redir_boot_q) |=> redir_valid_o && $stable(redir_addr_o)); // R11

  AST_NO_DOUBLE_EVT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(trap_take && mret_take)); // R9
endmodule

bind trap_unit trap_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .trap_take     (trap_take),
  .mret_take     (mret_take),
  .trap_irq_i    (trap_irq_i),
  .trap_pc_i     (trap_pc_i),
  .epc           (epc),
  .vbase         (vbase),
  .en            (en),
  .prev_en       (prev_en),
  .cause_irq     (cause_irq),
  .redir_valid_o (redir_valid_o),
  .redir_ready_i (redir_ready_i),
  .redir_boot_q  (redir_boot_q),
  .redir_addr_o  (redir_addr_o)
);

// File: tb/sim_trap_unit.sv
module sim_trap_unit;
  localparam int XLEN = 32;
  localparam int CW = 11;
  localparam int NE = 9;
  localparam time TCK = 20ns;
  localparam logic [31:0] BOOT = 32'h8000_0080;

  logic clk = 1'b0, rst_n = 1'b0;
  logic trap_valid = 0, trap_irq = 0, mret = 0, rdy = 0, we = 0;
  logic [CW-1:0] code = '0;
  logic [NE-1:0] vec = '0;
  logic [31:0] pc = '0, wdata = '0;
  logic [1:0] sel = '0;
  logic evt_ready, rvalid;
  logic [31:0] raddr, rdata;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(TCK/2) clk = ~clk;

  trap_unit #(.MTVEC_INIT(32'h0000_20FF)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .boot_addr_i(BOOT),
    .trap_valid_i(trap_valid), .trap_irq_i(trap_irq), .trap_code_i(code),
    .exc_vec_i(vec), .trap_pc_i(pc), .mret_i(mret),
    .evt_ready_o(evt_ready), .redir_valid_o(rvalid), .redir_ready_i(rdy),
    .redir_addr_o(raddr), .csr_we_i(we), .csr_sel_i(sel),
    .csr_wdata_i(wdata), .csr_rdata_o(rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] v);
    sel = s; #1; v = rdata;
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk); we = 1; sel = s; wdata = d;
    @(negedge clk); we = 0;
  endtask

  // one trap; checks redirect after the next edge
  task automatic trap(input logic irq, input logic [CW-1:0] c, input logic [NE-1:0] v,
                      input logic [31:0] p, input logic [31:0] exp_addr, input string req);
    @(negedge clk); trap_valid = 1; trap_irq = irq; code = c; vec = v; pc = p;
    @(negedge clk); trap_valid = 0; vec = '0;
    chk({req, " valid"}, 32'(rvalid), 32'd1);
    chk({req, " addr"}, raddr, exp_addr);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rdy = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 boot valid", 32'(rvalid), 32'd1);
    chk("R1 boot addr", raddr, BOOT);
    rd(2'd0, v); chk("R1 status", v, 32'h0);
    rd(2'd2, v); chk("R1 epc", v, 32'h0);
    rd(2'd3, v); chk("R1 cause", v, 32'h0);
    rd(2'd1, v); chk("R1 vbase", v, 32'h0000_2001);
    rdy = 1;
    @(negedge clk);
    chk("R11 drop after accept", 32'(rvalid), 32'd0);
  endtask

  task automatic t_irq_vectored();
    logic [31:0] v;
    wr(2'd0, 32'h0000_0008);
    trap(1, 11'd11, '0, 32'h0000_0100, 32'h0000_202C, "R4 vectored");
    rd(2'd2, v); chk("R2 epc", v, 32'h0000_0100);
    rd(2'd0, v); chk("R2 status", v, 32'h0000_0080);
    rd(2'd3, v); chk("R5 cause irq", v, 32'h8000_000B);
  endtask

  task automatic t_mret();
    logic [31:0] v;
    @(negedge clk); mret = 1;
    @(negedge clk); mret = 0;
    chk("R8 ret valid", 32'(rvalid), 32'd1);
    chk("R8 ret addr", raddr, 32'h0000_0100);
    rd(2'd0, v); chk("R8 status", v, 32'h0000_0088);
  endtask

  task automatic t_irq_direct();
    logic [31:0] v;
    wr(2'd1, 32'h0000_3000);
    rd(2'd1, v); chk("R10 vbase direct", v, 32'h0000_3000);
    trap(1, 11'd31, '0, 32'h0000_0200, 32'h0000_3000, "R4 direct");
    wr(2'd1, 32'h0000_40FF);
    rd(2'd1, v); chk("R10 vbase mask", v, 32'h0000_4001);
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, v); chk("R10 status mask", v, 32'h0000_0088);
  endtask

  task automatic t_prio();
    logic [31:0] v;
    int exp_codes[NE] = '{1, 49, 48, 2, 8, 11, 3, 7, 5};
    trap(0, 11'd0, 9'b0_0000_1000, 32'h0000_0300, 32'h0000_4000, "R3 exc base vectored");
    rd(2'd3, v); chk("R5 cause exc", v, 32'd2);
    for (int i = 0; i < NE; i++) begin
      trap(0, 11'd0, NE'({NE{1'b1}} << i), 32'h400 + 32'(i), 32'h0000_4000, "R6 prio");
      rd(2'd3, v); chk("R6 prio code", v, 32'(exp_codes[i]));
      trap(0, 11'd0, NE'(1) << i, 32'h400, 32'h0000_4000, "R6 single");
      rd(2'd3, v); chk("R6 single code", v, 32'(exp_codes[i]));
    end
  endtask

  task automatic t_empty();
    logic [31:0] v;
    trap(0, 11'd13, '0, 32'h0000_0480, 32'h0000_4000, "R7 empty vec");
    rd(2'd3, v); chk("R7 cause code", v, 32'd13);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    wr(2'd0, 32'h0000_0080);
    @(negedge clk); trap_valid = 1; mret = 1; trap_irq = 0; vec = 9'h040; pc = 32'h500;
    @(negedge clk); trap_valid = 0; mret = 0; vec = '0;
    chk("R9 trap wins addr", raddr, 32'h0000_4000);
    rd(2'd0, v); chk("R9 status", v, 32'h0);
    rd(2'd2, v); chk("R9 epc", v, 32'h500);
  endtask

  task automatic t_csr_vs_trap();
    logic [31:0] v;
    wr(2'd0, 32'h0000_0008);
    @(negedge clk); trap_valid = 1; trap_irq = 0; vec = 9'h001; pc = 32'h600;
    we = 1; sel = 2'd2; wdata = 32'hDEAD_BEE0;
    @(negedge clk); trap_valid = 0; vec = '0; we = 0;
    rd(2'd2, v); chk("R12 epc", v, 32'h600);
    @(negedge clk); trap_valid = 1; vec = 9'h001; pc = 32'h610;
    we = 1; sel = 2'd0; wdata = 32'h0000_0008;
    @(negedge clk); trap_valid = 0; vec = '0; we = 0;
    rd(2'd0, v); chk("R12 status", v, 32'h0);
    wr(2'd3, 32'h8000_0123);
    rd(2'd3, v); chk("R10 cause write ignored", v, 32'd1);
  endtask

  task automatic t_backpressure();
    logic [31:0] v;
    rdy = 0;
    trap(0, 11'd0, 9'h100, 32'h0000_0700, 32'h0000_4000, "R11 first");
    chk("R11 busy", 32'(evt_ready), 32'd0);
    @(negedge clk); mret = 1; trap_valid = 1; trap_irq = 1; code = 11'd5; pc = 32'h777;
    repeat (2) @(negedge clk);
    chk("R11 held valid", 32'(rvalid), 32'd1);
    chk("R11 held addr", raddr, 32'h0000_4000);
    mret = 0; trap_valid = 0;
    rd(2'd2, v); chk("R11 epc unchanged", v, 32'h700);
    rd(2'd3, v); chk("R11 cause unchanged", v, 32'd5);
    rdy = 1;
    @(negedge clk);
    chk("R11 released", 32'(rvalid), 32'd0);
  endtask

  initial begin
    #(TCK * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_irq_vectored();
    t_mret();
    t_irq_direct();
    t_prio();
    t_empty();
    t_collide();
    t_csr_vs_trap();
    t_backpressure();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule